// File: doc/BRIEF.md
# Streaming Fixed-Point Complex Multiplier

This block multiplies a stream of complex samples by a stream of complex oscillator values. It produces one truncated complex product for each pair of beats it consumes. Each operand stream has its own valid/ready/last handshake, and so does the result. A pair of operands is taken only in a cycle where both input streams offer data and the result side can move.

The sample operand carries two 24-bit lanes. Each lane holds a signed value with 21 significant bits and 15 fractional bits. The oscillator operand carries two signed 16-bit values with 14 fractional bits.

The block forms the four real cross products and combines them into real and imaginary sums at a full 38 bits. It then keeps the upper 32 bits of each sum, so the result has 23 fractional bits. The pipeline is four register stages deep:

1. The operands are unpacked.
2. The four products are formed.
3. The sum and difference are taken.
4. The low bits are dropped.

All four stages advance on a single enable, which is the result-side ready. While the result side is stalled, the whole pipeline holds still. No rounding, saturation or buffering between the two inputs is done.

Top module: `cmplx_stream_mult`

## Requirements
- R1: Reset (synchronous, active high) empties the pipeline. `y_tvalid` is low in the first cycle after reset and stays low until a beat has been accepted.
- R2: Operand A puts the real part in lane bits [23:0] and the imaginary part in bits [47:24]. Only the low 21 bits of each lane ([20:0] and [44:24]) are used, as two's-complement values. Lane bits [23:21] and [47:45] have no effect on the result.
- R3: Operand B puts the real (cosine) part in bits [15:0] and the imaginary (sine) part in bits [31:16], each as a signed 16-bit value.
- R4: Result bits [31:0] equal bits [37:6] of the exact 38-bit value Ar·Br − Ai·Bi.
- R5: Result bits [63:32] equal bits [37:6] of the exact 38-bit value Ar·Bi + Ai·Br.
- R6: `a_tready` and `b_tready` are always equal to `y_tready`. A pair is consumed only in a cycle where `a_tvalid`, `b_tvalid` and that ready are all high.
- R7: When only one input is valid, nothing is consumed and no result appears. The waiting beat is the one used once the other input turns valid.
- R8: `y_tlast` of a result equals the OR of `a_tlast` and `b_tlast` of the pair it came from.
- R9: With `y_tready` held high, a pair accepted at a clock edge appears on the result port after the third following edge, which is a latency of 4 cycles.
- R10: While `y_tvalid` is high and `y_tready` is low, `y_tvalid`, `y_tdata` and `y_tlast` hold their values.
- R11: Results leave in the order the pairs were accepted, exactly one result per accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_tdata | input | 48 | Sample operand {imag lane, real lane} |
| a_tvalid | input | 1 | Sample operand valid |
| a_tlast | input | 1 | Sample operand last |
| a_tready | output | 1 | Sample operand ready |
| b_tdata | input | 32 | Oscillator operand {sine, cosine} |
| b_tvalid | input | 1 | Oscillator operand valid |
| b_tlast | input | 1 | Oscillator operand last |
| b_tready | output | 1 | Oscillator operand ready |
| y_tdata | output | 64 | Product {imag[31:0], real[31:0]} |
| y_tvalid | output | 1 | Product valid |
| y_tlast | output | 1 | Product last |
| y_tready | input | 1 | Product ready |

## Verification
A full sweep crosses six corner values for each of the four operand components: zero, plus one, minus one, the positive limit, the negative limit and a mid value. This separates a swapped lane or component, a wrong sign on either product pair, and a bad sign extension. Every other beat in the sweep fills the unused lane bits with garbage, which shows whether those bits leak into the result.

A stretch with only one input valid shows whether the block consumes half a pair. A run with randomly gated valids and ready exposes any slip in ordering, latency or last alignment under backpressure. A reset in the middle of a stream checks that no stale beat survives.

// File: rtl/cmplx_mult_pkg.sv
package cmplx_mult_pkg;

    // Default widths of the operand lanes and of the result components.
    localparam int A_LANE_W_DEF = 24;
    localparam int A_SIG_W_DEF  = 21;
    localparam int B_W_DEF      = 16;
    localparam int OUT_W_DEF    = 32;

    // Number of register stages between input acceptance and the result port.
    localparam int PIPE_STAGES  = 4;

    // Control word carried beside the data through every stage.
    typedef struct packed {
        logic valid;
        logic last;
    } beat_ctl_t;

    localparam beat_ctl_t CTL_EMPTY = '{valid: 1'b0, last: 1'b0};

endpackage

// File: rtl/cmplx_mult_unpack.sv
module cmplx_mult_unpack
    import cmplx_mult_pkg::*;
#(
    parameter int A_LANE_W = A_LANE_W_DEF,
    parameter int A_SIG_W  = A_SIG_W_DEF,
    parameter int B_W      = B_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [2*A_LANE_W-1:0]       a_word,
    input  logic [2*B_W-1:0]            b_word,
    input  beat_ctl_t                   ctl_in,
    output logic signed [A_SIG_W-1:0]   a_re,
    output logic signed [A_SIG_W-1:0]   a_im,
    output logic signed [B_W-1:0]       b_re,
    output logic signed [B_W-1:0]       b_im,
    output beat_ctl_t                   ctl_out
);

    localparam int PAD_W = A_LANE_W - A_SIG_W;

    // Lane fields: real in the low lane, imaginary in the high lane.
    logic [A_LANE_W-1:0] lane_re;
    logic [A_LANE_W-1:0] lane_im;

    assign lane_re = a_word[A_LANE_W-1:0];
    assign lane_im = a_word[2*A_LANE_W-1:A_LANE_W];

    // Pad bits above the significant field carry no information.
    generate
        if (PAD_W > 0) begin : g_pad
            logic pad_unused;
            assign pad_unused = ^{lane_re[A_LANE_W-1:A_SIG_W],
                                  lane_im[A_LANE_W-1:A_SIG_W]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= CTL_EMPTY;
        end else if (en) begin
            ctl_out <= ctl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            a_re <= lane_re[A_SIG_W-1:0];
            a_im <= lane_im[A_SIG_W-1:0];
            b_re <= b_word[B_W-1:0];
            b_im <= b_word[2*B_W-1:B_W];
        end
    end

endmodule

// File: rtl/cmplx_mult_products.sv
module cmplx_mult_products
    import cmplx_mult_pkg::*;
#(
    parameter int A_SIG_W = A_SIG_W_DEF,
    parameter int B_W     = B_W_DEF,
    localparam int PROD_W = A_SIG_W + B_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [A_SIG_W-1:0]  a_re,
    input  logic signed [A_SIG_W-1:0]  a_im,
    input  logic signed [B_W-1:0]      b_re,
    input  logic signed [B_W-1:0]      b_im,
    input  beat_ctl_t                  ctl_in,
    output logic signed [PROD_W-1:0]   p_rr,
    output logic signed [PROD_W-1:0]   p_ii,
    output logic signed [PROD_W-1:0]   p_ri,
    output logic signed [PROD_W-1:0]   p_ir,
    output beat_ctl_t                  ctl_out
);

    localparam int N_PROD = 4;

    // Product k: 0 = re*re, 1 = im*im, 2 = re*im, 3 = im*re (A first).
    logic signed [A_SIG_W-1:0] a_pick [N_PROD];
    logic signed [B_W-1:0]     b_pick [N_PROD];
    logic signed [PROD_W-1:0]  prod_q [N_PROD];

    generate
        for (genvar k = 0; k < N_PROD; k++) begin : g_mul
            if (k == 0 || k == 2) begin : g_a_re
                assign a_pick[k] = a_re;
            end else begin : g_a_im
                assign a_pick[k] = a_im;
            end

            if (k == 0 || k == 3) begin : g_b_re
                assign b_pick[k] = b_re;
            end else begin : g_b_im
                assign b_pick[k] = b_im;
            end

            always_ff @(posedge clk) begin
                if (en) begin
                    prod_q[k] <= PROD_W'(a_pick[k]) * PROD_W'(b_pick[k]);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= CTL_EMPTY;
        end else if (en) begin
            ctl_out <= ctl_in;
        end
    end

    assign p_rr = prod_q[0];
    assign p_ii = prod_q[1];
    assign p_ri = prod_q[2];
    assign p_ir = prod_q[3];

endmodule

// File: rtl/cmplx_mult_combine.sv
module cmplx_mult_combine
    import cmplx_mult_pkg::*;
#(
    parameter int PROD_W  = A_SIG_W_DEF + B_W_DEF,
    localparam int FULL_W = PROD_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [PROD_W-1:0]   p_rr,
    input  logic signed [PROD_W-1:0]   p_ii,
    input  logic signed [PROD_W-1:0]   p_ri,
    input  logic signed [PROD_W-1:0]   p_ir,
    input  beat_ctl_t                  ctl_in,
    output logic signed [FULL_W-1:0]   sum_re,
    output logic signed [FULL_W-1:0]   sum_im,
    output beat_ctl_t                  ctl_out
);

    // One growth bit keeps both sums exact.
    always_ff @(posedge clk) begin
        if (en) begin
            sum_re <= FULL_W'(p_rr) - FULL_W'(p_ii);
            sum_im <= FULL_W'(p_ri) + FULL_W'(p_ir);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= CTL_EMPTY;
        end else if (en) begin
            ctl_out <= ctl_in;
        end
    end

endmodule

// File: rtl/cmplx_mult_trim.sv
module cmplx_mult_trim
    import cmplx_mult_pkg::*;
#(
    parameter int FULL_W = A_SIG_W_DEF + B_W_DEF + 1,
    parameter int OUT_W  = OUT_W_DEF,
    localparam int DROP_W = FULL_W - OUT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [FULL_W-1:0]   sum_re,
    input  logic signed [FULL_W-1:0]   sum_im,
    input  beat_ctl_t                  ctl_in,
    output logic [2*OUT_W-1:0]         word_out,
    output beat_ctl_t                  ctl_out
);

    // Low bits are discarded without rounding.
    logic drop_unused;
    assign drop_unused = ^{sum_re[DROP_W-1:0], sum_im[DROP_W-1:0]};

    always_ff @(posedge clk) begin
        if (en) begin
            word_out <= {sum_im[FULL_W-1 -: OUT_W], sum_re[FULL_W-1 -: OUT_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= CTL_EMPTY;
        end else if (en) begin
            ctl_out <= ctl_in;
        end
    end

endmodule

// File: rtl/cmplx_stream_mult.sv
module cmplx_stream_mult
    import cmplx_mult_pkg::*;
#(
    parameter int A_LANE_W = A_LANE_W_DEF,
    parameter int A_SIG_W  = A_SIG_W_DEF,
    parameter int B_W      = B_W_DEF,
    parameter int OUT_W    = OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2*A_LANE_W-1:0]   a_tdata,
    input  logic                    a_tvalid,
    input  logic                    a_tlast,
    output logic                    a_tready,
    input  logic [2*B_W-1:0]        b_tdata,
    input  logic                    b_tvalid,
    input  logic                    b_tlast,
    output logic                    b_tready,
    output logic [2*OUT_W-1:0]      y_tdata,
    output logic                    y_tvalid,
    output logic                    y_tlast,
    input  logic                    y_tready
);

    localparam int PROD_W = A_SIG_W + B_W;
    localparam int FULL_W = PROD_W + 1;

    // Single stall enable: every stage moves only when the result side moves.
    logic      adv;
    beat_ctl_t ctl_in;
    beat_ctl_t ctl_s1;
    beat_ctl_t ctl_s2;
    beat_ctl_t ctl_s3;
    beat_ctl_t ctl_s4;

    assign adv      = y_tready;
    assign a_tready = adv;
    assign b_tready = adv;

    // A pair enters only when both sides offer a beat.
    assign ctl_in.valid = a_tvalid & b_tvalid;
    assign ctl_in.last  = a_tlast | b_tlast;

    logic signed [A_SIG_W-1:0] s1_a_re;
    logic signed [A_SIG_W-1:0] s1_a_im;
    logic signed [B_W-1:0]     s1_b_re;
    logic signed [B_W-1:0]     s1_b_im;

    cmplx_mult_unpack #(
        .A_LANE_W (A_LANE_W),
        .A_SIG_W  (A_SIG_W),
        .B_W      (B_W)
    ) u_unpack (
        .clk     (clk),
        .rst     (rst),
        .en      (adv),
        .a_word  (a_tdata),
        .b_word  (b_tdata),
        .ctl_in  (ctl_in),
        .a_re    (s1_a_re),
        .a_im    (s1_a_im),
        .b_re    (s1_b_re),
        .b_im    (s1_b_im),
        .ctl_out (ctl_s1)
    );

    logic signed [PROD_W-1:0] s2_rr;
    logic signed [PROD_W-1:0] s2_ii;
    logic signed [PROD_W-1:0] s2_ri;
    logic signed [PROD_W-1:0] s2_ir;

    cmplx_mult_products #(
        .A_SIG_W (A_SIG_W),
        .B_W     (B_W)
    ) u_products (
        .clk     (clk),
        .rst     (rst),
        .en      (adv),
        .a_re    (s1_a_re),
        .a_im    (s1_a_im),
        .b_re    (s1_b_re),
        .b_im    (s1_b_im),
        .ctl_in  (ctl_s1),
        .p_rr    (s2_rr),
        .p_ii    (s2_ii),
        .p_ri    (s2_ri),
        .p_ir    (s2_ir),
        .ctl_out (ctl_s2)
    );

    logic signed [FULL_W-1:0] s3_re;
    logic signed [FULL_W-1:0] s3_im;

    cmplx_mult_combine #(
        .PROD_W (PROD_W)
    ) u_combine (
        .clk     (clk),
        .rst     (rst),
        .en      (adv),
        .p_rr    (s2_rr),
        .p_ii    (s2_ii),
        .p_ri    (s2_ri),
        .p_ir    (s2_ir),
        .ctl_in  (ctl_s2),
        .sum_re  (s3_re),
        .sum_im  (s3_im),
        .ctl_out (ctl_s3)
    );

    cmplx_mult_trim #(
        .FULL_W (FULL_W),
        .OUT_W  (OUT_W)
    ) u_trim (
        .clk      (clk),
        .rst      (rst),
        .en       (adv),
        .sum_re   (s3_re),
        .sum_im   (s3_im),
        .ctl_in   (ctl_s3),
        .word_out (y_tdata),
        .ctl_out  (ctl_s4)
    );

    assign y_tvalid = ctl_s4.valid;
    assign y_tlast  = ctl_s4.last;

endmodule

// File: rtl/cmplx_stream_mult_chk.sv
module cmplx_stream_mult_chk #(
    parameter int Y_W = 64
) (
    input logic           clk,
    input logic           rst,
    input logic           a_tvalid,
    input logic           a_tlast,
    input logic           a_tready,
    input logic           b_tvalid,
    input logic           b_tlast,
    input logic [Y_W-1:0] y_tdata,
    input logic           y_tvalid,
    input logic           y_tlast,
    input logic           y_tready
);

    localparam int DEPTH = 4;

    // Port-level record of accepted pairs, moving with the result-side ready.
    logic [DEPTH-1:0] take_sh;
    logic [DEPTH-1:0] last_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_sh <= '0;
            last_sh <= '0;
        end else if (y_tready) begin
            take_sh <= {take_sh[DEPTH-2:0], a_tvalid & b_tvalid & a_tready};
            last_sh <= {last_sh[DEPTH-2:0], a_tlast | b_tlast};
        end
    end

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !y_tvalid);                                             // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        y_tvalid == take_sh[DEPTH-1]);                                         // R9

    AST_LAST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        y_tvalid |-> (y_tlast == last_sh[DEPTH-1]));                           // R8

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (y_tvalid && !y_tready) |=> (y_tvalid && $stable(y_tdata) && $stable(y_tlast))); // R10

endmodule

bind cmplx_stream_mult cmplx_stream_mult_chk #(
    .Y_W (2*OUT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_tvalid (a_tvalid),
    .a_tlast  (a_tlast),
    .a_tready (a_tready),
    .b_tvalid (b_tvalid),
    .b_tlast  (b_tlast),
    .y_tdata  (y_tdata),
    .y_tvalid (y_tvalid),
    .y_tlast  (y_tlast),
    .y_tready (y_tready)
);

// File: tb/sim_cmplx_stream_mult.sv
module sim_cmplx_stream_mult;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] a_tdata = '0;
    logic        a_tvalid = 1'b0;
    logic        a_tlast = 1'b0;
    logic        a_tready;
    logic [31:0] b_tdata = '0;
    logic        b_tvalid = 1'b0;
    logic        b_tlast = 1'b0;
    logic        b_tready;
    logic [63:0] y_tdata;
    logic        y_tvalid;
    logic        y_tlast;
    logic        y_tready = 1'b1;

    always #5 clk = ~clk;

    cmplx_stream_mult u0 (
        .clk      (clk),
        .rst      (rst),
        .a_tdata  (a_tdata),
        .a_tvalid (a_tvalid),
        .a_tlast  (a_tlast),
        .a_tready (a_tready),
        .b_tdata  (b_tdata),
        .b_tvalid (b_tvalid),
        .b_tlast  (b_tlast),
        .b_tready (b_tready),
        .y_tdata  (y_tdata),
        .y_tvalid (y_tvalid),
        .y_tlast  (y_tlast),
        .y_tready (y_tready)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Scoreboard of accepted pairs.
    logic [63:0] exp_d [0:4095];
    logic        exp_l [0:4095];
    int          exp_c [0:4095];
    int          wr = 0;
    int          rd = 0;
    bit          lat_mode = 1'b0;
    bit          prev_stall = 1'b0;
    logic [63:0] prev_d;
    logic        prev_l;

    // Expected product built from the requirement arithmetic.
    function automatic logic [63:0] model(logic [47:0] a, logic [31:0] b);
        longint ar, ai, br, bi, re, im;
        ar = longint'($signed(a[20:0]));
        ai = longint'($signed(a[44:24]));
        br = longint'($signed(b[15:0]));
        bi = longint'($signed(b[31:16]));
        re = ar * br - ai * bi;
        im = ar * bi + ai * br;
        return {im[37:6], re[37:6]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge, once the inputs for the next rising edge are set.
    task automatic tick();
        #1;
        if (!rst) begin
            chk(a_tready == y_tready && b_tready == y_tready, "R6", "input readies",
                {62'd0, a_tready, b_tready}, {62'd0, y_tready, y_tready});
            if (prev_stall) begin
                chk(y_tvalid, "R10", "valid dropped during stall", {63'd0, y_tvalid}, 64'd1);
                chk(y_tdata == prev_d, "R10", "data moved during stall", y_tdata, prev_d);
                chk(y_tlast == prev_l, "R10", "last moved during stall", {63'd0, y_tlast}, {63'd0, prev_l});
            end
            if (y_tvalid && y_tready) begin
                if (rd == wr) begin
                    chk(1'b0, "R11", "result without accepted pair", y_tdata, 64'd0);
                end else begin
                    chk(y_tdata == exp_d[rd], "R4 R5", "product", y_tdata, exp_d[rd]);
                    chk(y_tlast == exp_l[rd], "R8", "last flag", {63'd0, y_tlast}, {63'd0, exp_l[rd]});
                    if (lat_mode)
                        chk(cyc - exp_c[rd] == 4, "R9", "latency",
                            64'(cyc - exp_c[rd]), 64'd4);
                    rd++;
                end
            end
            prev_stall = y_tvalid && !y_tready;
            prev_d     = y_tdata;
            prev_l     = y_tlast;
            if (a_tvalid && b_tvalid && a_tready) begin
                exp_d[wr] = model(a_tdata, b_tdata);
                exp_l[wr] = a_tlast | b_tlast;
                exp_c[wr] = cyc;
                wr++;
            end
        end else begin
            prev_stall = 1'b0;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        a_tvalid = 1'b0;
        b_tvalid = 1'b0;
        a_tlast  = 1'b0;
        b_tlast  = 1'b0;
    endtask

    task automatic drain(int n);
        idle_inputs();
        y_tready = 1'b1;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    int va [6] = '{0, 1, -1, 1048575, -1048576, 12345};
    int vb [6] = '{0, 1, -1, 32767, -32768, 16384};

    initial begin
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;

        // R1: pipeline empty after reset while idle
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!y_tvalid, "R1", "valid after reset", {63'd0, y_tvalid}, 64'd0);
        end

        // R9: single isolated beat
        lat_mode = 1'b1;
        a_tdata  = {24'h000123, 24'h0FFFFF};
        b_tdata  = {16'h4000, 16'hC000};
        a_tvalid = 1'b1;
        b_tvalid = 1'b1;
        tick();
        drain(8);

        // R2 R3 R4 R5 R8 R9: corner sweep with garbage in the unused lane bits
        begin
            int idx = 0;
            for (int i0 = 0; i0 < 6; i0++)
                for (int i1 = 0; i1 < 6; i1++)
                    for (int i2 = 0; i2 < 6; i2++)
                        for (int i3 = 0; i3 < 6; i3++) begin
                            logic [2:0] pad_r, pad_i;
                            pad_r = (idx % 2 == 1) ? 3'(idx) : {3{va[i0] < 0}};
                            pad_i = (idx % 2 == 1) ? 3'(idx >> 3) : {3{va[i1] < 0}};
                            a_tdata  = {pad_i, 21'(va[i1]), pad_r, 21'(va[i0])};
                            b_tdata  = {16'(vb[i3]), 16'(vb[i2])};
                            a_tlast  = (idx % 5 == 0);
                            b_tlast  = (idx % 7 == 0);
                            a_tvalid = 1'b1;
                            b_tvalid = 1'b1;
                            tick();
                            idx++;
                        end
        end
        drain(8);
        chk(rd == wr, "R11", "sweep results count", 64'(rd), 64'(wr));
        lat_mode = 1'b0;

        // R7: one side valid only
        a_tdata  = {24'h0ABCDE, 24'h1F0001};
        a_tvalid = 1'b1;
        b_tvalid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!y_tvalid, "R7", "result with only A valid", {63'd0, y_tvalid}, 64'd0);
        end
        a_tvalid = 1'b0;
        b_tdata  = {16'h8000, 16'h7FFF};
        b_tvalid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!y_tvalid, "R7", "result with only B valid", {63'd0, y_tvalid}, 64'd0);
        end
        chk(wr == rd, "R7", "pairs taken with one side valid", 64'(wr), 64'(rd));
        a_tvalid = 1'b1;
        tick();
        drain(8);
        chk(rd == wr && wr > 0, "R7", "waiting beat consumed once", 64'(rd), 64'(wr));

        // R6 R10 R11: random valids and backpressure
        for (int i = 0; i < 400; i++) begin
            a_tdata  = {$urandom, $urandom};
            b_tdata  = $urandom;
            a_tlast  = ($urandom % 4 == 0);
            b_tlast  = ($urandom % 4 == 0);
            a_tvalid = ($urandom % 4 != 0);
            b_tvalid = ($urandom % 4 != 0);
            y_tready = ($urandom % 3 != 0);
            tick();
        end
        drain(10);
        chk(rd == wr, "R11", "results after backpressure", 64'(rd), 64'(wr));

        // R1: reset in the middle of a stream
        a_tvalid = 1'b1;
        b_tvalid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            a_tdata = {24'(i + 7), 24'(i + 3)};
            b_tdata = {16'(i), 16'h4000};
            tick();
        end
        idle_inputs();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        wr  = 0;
        rd  = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!y_tvalid, "R1", "stale beat after reset", {63'd0, y_tvalid}, 64'd0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule